// File: doc/BRIEF.md
# Processor Debug Event Controller

This block sits beside the execute stage and looks at one instruction per cycle. For that instruction it sees three flags: a taken branch, a trap whose condition holds, and a non-critical return from interrupt. It also sees the instruction address. It combines these flags with per-kind enables, two debug mode bits, a debug-action code and the machine-state debug-interrupt-enable bit. From them it produces sticky status bits, a stop request with a captured PC, an instruction-suppress pulse, a debug interrupt pulse with a saved return address, and a trap-type program interrupt pulse.

The two modes are applied in a fixed order. External mode is tried first. If its action code asks for a halt, the core stops and nothing else happens. Otherwise the internal-mode rules are applied to the same event. A trap or return seen while debug interrupts are off leaves a pending record. That record turns into a late debug interrupt once the enable bit comes back, as long as software has not cleared the matching status bit first. All outputs are registered, so they appear one clock after the instruction is presented.

Top module: `dbg_evt_ctrl`

## Requirements
- R1: A branch event fires only when `ev_valid`, `ev_branch`, `cfg_branch_en` and `msr_dbg_en` are all 1; it then sets `dbg_status[1]`. With `msr_dbg_en` at 0 no branch status is recorded.
- R2: A trap event fires when `ev_valid`, `ev_trap` and `cfg_trap_en` are 1, whatever `msr_dbg_en` is; it sets `dbg_status[0]`. If `msr_dbg_en` is 0, `dbg_status[3]` (imprecise) is also set.
- R3: A return event fires when `ev_valid`, `ev_return` and `cfg_ret_en` are 1; it sets `dbg_status[2]`. With `msr_dbg_en` at 0 it also sets `dbg_status[3]`, and it raises neither suppress nor a program interrupt.
- R4: In external mode (`cfg_ext_mode`=1) with `cfg_action` equal to the stop code 2'b01, a fired event sets `stop_req` and loads `stop_pc` with `ev_addr` on the next cycle. No suppress or interrupt is raised.
- R5: In external mode with any other action code, execution continues and the internal-mode rules of R6 and R7 apply to the same event.
- R6: In internal mode (`cfg_int_mode`=1) with `msr_dbg_en`=1, a fired event gives one-cycle pulses on `suppress` and `dbg_irq` on the next cycle, and loads `save_addr` with `ev_addr`.
- R7: In internal mode with `msr_dbg_en`=0, a trap event gives one-cycle pulses on `suppress` and `prog_irq`, with no `dbg_irq`.
- R8: A trap or return that fires in internal mode with `msr_dbg_en`=0 leaves a pending record. In a later cycle, if `msr_dbg_en` is 1 and status bit 0 or 2 is still set after that cycle's clear, `dbg_irq` pulses once and `save_addr` takes that cycle's `ev_addr`. If both bits were cleared before that, no interrupt follows.
- R9: Status bits are sticky. A 1 in `sts_clr` clears the matching bit, and a new event setting the same bit in the same cycle wins over the clear.
- R10: `stop_req` stays 1 with `stop_pc` unchanged until `resume` is 1 on a clock edge. While stopped, events are not evaluated and no pending interrupt is delivered.
- R11: When several flags fire together, all their status bits are set, and the action follows the winner in the order trap, then branch, then return. For example, trap plus return with `msr_dbg_en`=0 in internal mode raises `prog_irq`.
- R12: Reset (`rst_n`=0) clears the status bits, the pending record, `stop_req`, `suppress`, `dbg_irq` and `prog_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An instruction is presented this cycle |
| ev_trap | input | 1 | Trap instruction with condition satisfied |
| ev_branch | input | 1 | Branch redirected to its target |
| ev_return | input | 1 | Non-critical return from interrupt |
| ev_addr | input | AW | Address of the presented instruction |
| cfg_trap_en | input | 1 | Trap event enable |
| cfg_branch_en | input | 1 | Branch event enable |
| cfg_ret_en | input | 1 | Return event enable |
| cfg_ext_mode | input | 1 | External debug mode |
| cfg_int_mode | input | 1 | Internal debug mode |
| cfg_action | input | ACT_W | External debug action code |
| msr_dbg_en | input | 1 | Debug interrupt enable from machine state |
| sts_clr | input | 4 | Write-one-to-clear strobe for the status bits |
| resume | input | 1 | Leave the stop state |
| dbg_status | output | 4 | Sticky status: 0 trap, 1 branch, 2 return, 3 imprecise |
| stop_req | output | 1 | Core stop request |
| stop_pc | output | AW | Address that caused the stop |
| suppress | output | 1 | Suppress the causing instruction |
| dbg_irq | output | 1 | Debug interrupt request pulse |
| save_addr | output | AW | Return address for the debug interrupt |
| prog_irq | output | 1 | Trap-type program interrupt request pulse |

## Verification
The assertions check properties that must hold on every cycle. A branch status bit may only rise when debug interrupts were enabled, and the imprecise bit only when they were off. A stop may only come from external mode, the stop PC holds steady while stopped, and nothing is raised in a cycle that follows a stopped cycle. The two interrupt pulses never coincide, and suppress never appears without one of them. Some behaviour depends on history across several cycles, and only the directed scenarios can show it: the late interrupt after the enable returns, its cancellation by a prior clear, the clear-versus-event race, the priority among simultaneous flags, and the exact captured addresses.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
    localparam int unsigned EV_N         = 3;
    localparam int unsigned EV_TRAP      = 0;
    localparam int unsigned EV_BRANCH    = 1;
    localparam int unsigned EV_RETURN    = 2;
    localparam int unsigned ST_W         = EV_N + 1;
    localparam int unsigned ST_IMPRECISE = EV_N;

    typedef struct packed {
        logic do_stop;
        logic do_dbg;
        logic do_prog;
        logic do_suppress;
        logic new_pend;
        logic set_imp;
    } act_t;
endpackage

// File: rtl/dbg_evt_qualify.sv
module dbg_evt_qualify
    import dbg_evt_pkg::*;
(
    input  logic            valid,
    input  logic [EV_N-1:0] flags,
    input  logic [EV_N-1:0] enables,
    input  logic            irq_en,
    output logic [EV_N-1:0] fire
);
    for (genvar k = 0; k < EV_N; k++) begin : g_kind
        if (k == EV_BRANCH) begin : g_gated
            // taken branches only count while debug interrupts are enabled
            assign fire[k] = valid && flags[k] && enables[k] && irq_en;
        end else begin : g_free
            assign fire[k] = valid && flags[k] && enables[k];
        end
    end
endmodule

// File: rtl/dbg_evt_select.sv
module dbg_evt_select
    import dbg_evt_pkg::*;
(
    input  logic [EV_N-1:0] fire,
    output logic [EV_N-1:0] win,
    output logic            any
);
    // lowest index wins: trap, then branch, then return
    always_comb begin
        win = '0;
        for (int k = EV_N - 1; k >= 0; k--) begin
            if (fire[k]) begin
                win = '0;
                win[k] = 1'b1;
            end
        end
    end
    assign any = |fire;
endmodule

// File: rtl/dbg_evt_action.sv
module dbg_evt_action
    import dbg_evt_pkg::*;
#(
    parameter int unsigned ACT_W    = 2,
    parameter logic [ACT_W-1:0] ACT_STOP = 1
) (
    input  logic [EV_N-1:0]  fire,
    input  logic [EV_N-1:0]  win,
    input  logic             any,
    input  logic             ext_mode,
    input  logic             int_mode,
    input  logic [ACT_W-1:0] action,
    input  logic             irq_en,
    output act_t             act
);
    logic go_int;

    always_comb begin
        act = '0;
        // external mode is consulted first; a halt ends processing here
        act.do_stop = any && ext_mode && (action == ACT_STOP);
        go_int      = any && !act.do_stop && int_mode;
        act.do_dbg  = go_int && irq_en;
        act.do_prog = go_int && !irq_en && win[EV_TRAP];
        act.do_suppress = act.do_dbg || act.do_prog;
        act.new_pend    = go_int && !irq_en;
        act.set_imp     = !irq_en && (fire[EV_TRAP] || fire[EV_RETURN]);
    end
endmodule

// File: rtl/dbg_evt_ctrl.sv
module dbg_evt_ctrl
    import dbg_evt_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned ACT_W    = 2,
    parameter logic [ACT_W-1:0] ACT_STOP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             ev_trap,
    input  logic             ev_branch,
    input  logic             ev_return,
    input  logic [AW-1:0]    ev_addr,
    input  logic             cfg_trap_en,
    input  logic             cfg_branch_en,
    input  logic             cfg_ret_en,
    input  logic             cfg_ext_mode,
    input  logic             cfg_int_mode,
    input  logic [ACT_W-1:0] cfg_action,
    input  logic             msr_dbg_en,
    input  logic [ST_W-1:0]  sts_clr,
    input  logic             resume,
    output logic [ST_W-1:0]  dbg_status,
    output logic             stop_req,
    output logic [AW-1:0]    stop_pc,
    output logic             suppress,
    output logic             dbg_irq,
    output logic [AW-1:0]    save_addr,
    output logic             prog_irq
);
    typedef struct packed {
        logic [ST_W-1:0] sts;
        logic            pending;
        logic            stop;
        logic [AW-1:0]   stop_pc;
        logic            suppress;
        logic            dbg_irq;
        logic [AW-1:0]   save_addr;
        logic            prog_irq;
    } state_t;

    state_t st_d, st_q;

    logic [EV_N-1:0] flags, enables, fire, win;
    logic            any;
    act_t            act;
    logic [ST_W-1:0] sts_kept;
    logic            defer_go;

    assign flags   = {ev_return, ev_branch, ev_trap};
    assign enables = {cfg_ret_en, cfg_branch_en, cfg_trap_en};

    dbg_evt_qualify u_qual (
        .valid   (ev_valid && !st_q.stop),
        .flags   (flags),
        .enables (enables),
        .irq_en  (msr_dbg_en),
        .fire    (fire)
    );

    dbg_evt_select u_sel (
        .fire (fire),
        .win  (win),
        .any  (any)
    );

    dbg_evt_action #(.ACT_W(ACT_W), .ACT_STOP(ACT_STOP)) u_act (
        .fire     (fire),
        .win      (win),
        .any      (any),
        .ext_mode (cfg_ext_mode),
        .int_mode (cfg_int_mode),
        .action   (cfg_action),
        .irq_en   (msr_dbg_en),
        .act      (act)
    );

    always_comb begin
        st_d          = st_q;
        st_d.suppress = 1'b0;
        st_d.dbg_irq  = 1'b0;
        st_d.prog_irq = 1'b0;

        // clear first, then set: a same-cycle event wins
        sts_kept = st_q.sts & ~sts_clr;
        st_d.sts = sts_kept | {act.set_imp, fire};

        defer_go = st_q.pending && msr_dbg_en && !st_q.stop
                   && (sts_kept[EV_TRAP] || sts_kept[EV_RETURN]);

        if (act.do_stop) begin
            st_d.stop    = 1'b1;
            st_d.stop_pc = ev_addr;
        end else if (st_q.stop && resume) begin
            st_d.stop = 1'b0;
        end

        if (act.do_dbg || defer_go) begin
            st_d.dbg_irq   = 1'b1;
            st_d.save_addr = ev_addr;
        end
        st_d.prog_irq = act.do_prog;
        st_d.suppress = act.do_suppress;

        st_d.pending = (st_q.pending && !defer_go) || act.new_pend;
        if (!(st_d.sts[EV_TRAP] || st_d.sts[EV_RETURN])) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_status = st_q.sts;
    assign stop_req   = st_q.stop;
    assign stop_pc    = st_q.stop_pc;
    assign suppress   = st_q.suppress;
    assign dbg_irq    = st_q.dbg_irq;
    assign save_addr  = st_q.save_addr;
    assign prog_irq   = st_q.prog_irq;
endmodule

// File: rtl/dbg_evt_ctrl_chk.sv
module dbg_evt_ctrl_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          msr_dbg_en,
    input logic          cfg_ext_mode,
    input logic          resume,
    input logic [3:0]    dbg_status,
    input logic          stop_req,
    input logic [AW-1:0] stop_pc,
    input logic          suppress,
    input logic          dbg_irq,
    input logic          prog_irq
);
    a_r1_branch_needs_de: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_status[1]) |-> $past(msr_dbg_en));

    a_r2_imprecise_de_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_status[3]) |-> !$past(msr_dbg_en));

    a_r4_stop_from_ext: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> $past(cfg_ext_mode));

    a_r6_suppress_has_irq: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |-> (dbg_irq || prog_irq));

    a_r7_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_irq && prog_irq));

    a_r10_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && $past(stop_req)) |-> $stable(stop_pc));

    a_r10_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_req) |-> !(dbg_irq || prog_irq || suppress));

    a_r10_resume_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && resume) |=> !stop_req);
endmodule

bind dbg_evt_ctrl dbg_evt_ctrl_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .msr_dbg_en   (msr_dbg_en),
    .cfg_ext_mode (cfg_ext_mode),
    .resume       (resume),
    .dbg_status   (dbg_status),
    .stop_req     (stop_req),
    .stop_pc      (stop_pc),
    .suppress     (suppress),
    .dbg_irq      (dbg_irq),
    .prog_irq     (prog_irq)
);

// File: tb/dbg_evt_ctrl_test.sv
`timescale 1ns/1ps
module dbg_evt_ctrl_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 0, ev_trap = 0, ev_branch = 0, ev_return = 0;
    logic [AW-1:0] ev_addr = '0;
    logic          cfg_trap_en = 0, cfg_branch_en = 0, cfg_ret_en = 0;
    logic          cfg_ext_mode = 0, cfg_int_mode = 0;
    logic [1:0]    cfg_action = 2'b00;
    logic          msr_dbg_en = 0;
    logic [3:0]    sts_clr = '0;
    logic          resume = 0;
    logic [3:0]    dbg_status;
    logic          stop_req, suppress, dbg_irq, prog_irq;
    logic [AW-1:0] stop_pc, save_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dbg_evt_ctrl #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_trap(ev_trap),
        .ev_branch(ev_branch), .ev_return(ev_return), .ev_addr(ev_addr),
        .cfg_trap_en(cfg_trap_en), .cfg_branch_en(cfg_branch_en),
        .cfg_ret_en(cfg_ret_en), .cfg_ext_mode(cfg_ext_mode),
        .cfg_int_mode(cfg_int_mode), .cfg_action(cfg_action),
        .msr_dbg_en(msr_dbg_en), .sts_clr(sts_clr), .resume(resume),
        .dbg_status(dbg_status), .stop_req(stop_req), .stop_pc(stop_pc),
        .suppress(suppress), .dbg_irq(dbg_irq), .save_addr(save_addr),
        .prog_irq(prog_irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {ev_valid, ev_trap, ev_branch, ev_return} = '0;
        {cfg_trap_en, cfg_branch_en, cfg_ret_en, cfg_ext_mode, cfg_int_mode} = '0;
        cfg_action = 2'b00; msr_dbg_en = 0; sts_clr = '0; resume = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // present one instruction at a falling edge; outputs are valid at the next one
    task automatic issue(input logic t, input logic b, input logic r, input logic [AW-1:0] a);
        ev_valid = 1; ev_trap = t; ev_branch = b; ev_return = r; ev_addr = a;
        @(negedge clk);
        ev_valid = 0; ev_trap = 0; ev_branch = 0; ev_return = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R12 status", dbg_status, 0);
        check("R12 stop", stop_req, 0);
        check("R12 irqs", {suppress, dbg_irq, prog_irq}, 0);
    endtask

    task automatic t_branch();
        do_reset();
        cfg_int_mode = 1; cfg_branch_en = 1; msr_dbg_en = 0;
        issue(0, 1, 0, 32'h100);
        check("R1 no branch with DE off", dbg_status, 0);
        check("R1 no irq with DE off", dbg_irq, 0);
        msr_dbg_en = 1; cfg_branch_en = 0;
        issue(0, 1, 0, 32'h104);
        check("R1 disabled branch", dbg_status, 0);
        cfg_branch_en = 1;
        issue(0, 1, 0, 32'h108);
        check("R1 branch status", dbg_status, 4'b0010);
        check("R6 suppress+dbg_irq", {suppress, dbg_irq, prog_irq}, 3'b110);
        check("R6 save_addr", save_addr, 32'h108);
        @(negedge clk);
        check("R6 pulse ends", {suppress, dbg_irq}, 0);
    endtask

    task automatic t_trap_defer();
        do_reset();
        cfg_int_mode = 1; cfg_trap_en = 1; msr_dbg_en = 0;
        issue(1, 0, 0, 32'h200);
        check("R2 trap+imprecise", dbg_status, 4'b1001);
        check("R7 prog_irq path", {suppress, dbg_irq, prog_irq}, 3'b101);
        @(negedge clk);
        check("R8 no irq while DE off", dbg_irq, 0);
        msr_dbg_en = 1; ev_addr = 32'h2A0;
        @(negedge clk);
        check("R8 deferred irq", dbg_irq, 1);
        check("R8 deferred save_addr", save_addr, 32'h2A0);
        check("R8 deferred no suppress", suppress, 0);
        @(negedge clk);
        check("R8 deferred once", dbg_irq, 0);
    endtask

    task automatic t_defer_cancel();
        do_reset();
        cfg_int_mode = 1; cfg_trap_en = 1; msr_dbg_en = 0;
        issue(1, 0, 0, 32'h300);
        sts_clr = 4'b0001;
        @(negedge clk);
        sts_clr = '0;
        check("R9 w1c clears trap", dbg_status, 4'b1000);
        msr_dbg_en = 1;
        @(negedge clk);
        check("R8 cleared status cancels", dbg_irq, 0);
    endtask

    task automatic t_clear_race();
        do_reset();
        cfg_branch_en = 1; msr_dbg_en = 1;
        issue(0, 1, 0, 32'h400);
        check("R9 sticky set", dbg_status, 4'b0010);
        @(negedge clk);
        check("R9 stays set", dbg_status, 4'b0010);
        sts_clr = 4'b0010;
        issue(0, 1, 0, 32'h404);
        sts_clr = '0;
        check("R9 event beats clear", dbg_status, 4'b0010);
        sts_clr = 4'b0010;
        @(negedge clk);
        sts_clr = '0;
        check("R9 clear alone", dbg_status, 0);
    endtask

    task automatic t_return();
        do_reset();
        cfg_int_mode = 1; cfg_ret_en = 1; msr_dbg_en = 1;
        issue(0, 0, 1, 32'h500);
        check("R3 return status", dbg_status, 4'b0100);
        check("R3 return dbg_irq", {suppress, dbg_irq, prog_irq}, 3'b110);
        sts_clr = 4'hF; @(negedge clk); sts_clr = '0;
        msr_dbg_en = 0;
        issue(0, 0, 1, 32'h504);
        check("R3 return DE off status", dbg_status, 4'b1100);
        check("R3 no suppress/prog", {suppress, dbg_irq, prog_irq}, 0);
    endtask

    task automatic t_ext_stop();
        do_reset();
        cfg_ext_mode = 1; cfg_int_mode = 1; cfg_action = 2'b01;
        cfg_branch_en = 1; cfg_trap_en = 1; msr_dbg_en = 1;
        issue(0, 1, 0, 32'h600);
        check("R4 stop_req", stop_req, 1);
        check("R4 stop_pc", stop_pc, 32'h600);
        check("R4 no irq on stop", {suppress, dbg_irq, prog_irq}, 0);
        sts_clr = 4'hF; @(negedge clk); sts_clr = '0;
        issue(1, 0, 0, 32'h604);
        check("R10 ignored while stopped", dbg_status, 0);
        check("R10 pc held", stop_pc, 32'h600);
        check("R10 still stopped", stop_req, 1);
        resume = 1; @(negedge clk); resume = 0;
        check("R10 resume", stop_req, 0);
    endtask

    task automatic t_ext_continue();
        do_reset();
        cfg_ext_mode = 1; cfg_int_mode = 1; cfg_action = 2'b10;
        cfg_trap_en = 1; msr_dbg_en = 1;
        issue(1, 0, 0, 32'h700);
        check("R5 no stop", stop_req, 0);
        check("R5 internal irq", {suppress, dbg_irq}, 2'b11);
        check("R5 save_addr", save_addr, 32'h700);
    endtask

    task automatic t_priority();
        do_reset();
        cfg_int_mode = 1; cfg_trap_en = 1; cfg_ret_en = 1; msr_dbg_en = 0;
        issue(1, 0, 1, 32'h800);
        check("R11 both status", dbg_status, 4'b1101);
        check("R11 trap wins prog_irq", {suppress, dbg_irq, prog_irq}, 3'b101);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_branch();
        t_trap_defer();
        t_defer_cancel();
        t_clear_race();
        t_return();
        t_ext_stop();
        t_ext_continue();
        t_priority();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule